// File: doc/BRIEF.md
# Pin-to-Resource Input Routing Matrix

This block connects twelve dedicated digital input pins to a small set of internal destinations: two counter clock inputs and two interrupt request lines, a high-priority and a low-priority one. Each pin has a three-bit selector. The selector either leaves the pin unconnected or names one destination. For an interrupt line, the selector also says whether a rising or a falling edge of the pin is the event. When several pins name the same destination, their contributions are merged by OR. One interrupt line may therefore be fed by one pin on its rising edge and by another pin on its falling edge at the same time.

Pins pass through a two-stage synchronizer before they are used. A falling-edge selection feeds the inverted synchronized pin into the OR for its line. A single edge detector on each line then turns every rise of the merged level into a one-cycle request pulse. Counter clock outputs are the merged synchronized levels, with no edge detection.

Each pin also has a direction bit, where 1 means output. It takes effect only while the pin's selector is zero, which means the pin is general I/O. A simple register port writes and reads the selectors and direction bits. The destinations themselves lie outside this block. The block carries no streaming data, so no port uses a valid/ready handshake. A register write is accepted on every cycle in which the write strobe is high, and nothing can stall it.

Top module: `pin_route_matrix`

## Requirements
- R1: After reset, every selector and direction bit is zero, all four destination outputs are low, every output-enable bit is low, and every register address reads back zero.
- R2: Addresses 0 to 5 each hold two selectors. Address k holds pin 2k in bits 2:0 and pin 2k+1 in bits 6:4. Reading returns exactly the values written, including code 1, and bits 3 and 7 read as zero.
- R3: Code 2 routes the pin to counter clock 0 and code 3 routes it to counter clock 1. The output equals the pin level two clock edges after the pin changes.
- R4: When several pins select the same counter clock, the output is the OR of their synchronized levels.
- R5: Code 4 (high-priority line) and code 5 (low-priority line) make a rising pin edge produce a one-cycle request pulse. The pulse is high after the second clock edge following the pin change and low after the third.
- R6: Code 6 (high-priority line) and code 7 (low-priority line) do the same for a falling pin edge.
- R7: On one interrupt line, rising-edge and falling-edge contributions from different pins are merged by OR before edge detection, so a pulse fires only when the merged level rises.
- R8: Code 0 (no connection) and code 1 (reserved) drive no destination, whatever the pin does.
- R9: Address 6 holds direction bits for pins 7 to 0 and address 7 holds them for pins 11 to 8 in bits 3:0. Output enable for a pin equals its direction bit only while its selector is zero, and is low otherwise.
- R10: Bits 7:4 of address 7 are not stored and read as zero. A cycle without a write leaves all stored configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Dedicated input pins, asynchronous to clk |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address for write and read |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i (combinational) |
| cnt0_clk_o | output | 1 | Counter 0 clock input |
| cnt1_clk_o | output | 1 | Counter 1 clock input |
| irq_hi_o | output | 1 | High-priority interrupt request pulse |
| irq_lo_o | output | 1 | Low-priority interrupt request pulse |
| pin_oe_o | output | 12 | Effective output enable per pin |

## Verification
A pin change driven at a falling clock edge appears on the counter clock outputs after the second following rising edge. Any interrupt pulse it causes is high in that same cycle and low after the third rising edge. The bench samples at the falling edges that lie exactly there. Configuration writes take effect at the next rising edge and can raise a merged level by themselves. For that reason the bench waits three cycles after each write before moving a pin. Read data is combinational, so it is sampled shortly after the address is set.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RS_NONE    = 3'd0,
    RS_RSVD    = 3'd1,
    RS_CNT0    = 3'd2,
    RS_CNT1    = 3'd3,
    RS_HI_RISE = 3'd4,
    RS_LO_RISE = 3'd5,
    RS_HI_FALL = 3'd6,
    RS_LO_FALL = 3'd7
  } route_sel_e;
endpackage

// File: rtl/prm_cfg_regs.sv
module prm_cfg_regs
  import prm_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int ADDR_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [7:0]                     wdata_i,
  output logic [7:0]                     rdata_o,
  output logic [NUM_PINS-1:0][SEL_W-1:0] sel_o,
  output logic [NUM_PINS-1:0]            dir_o
);
  localparam int SEL_BYTES = (NUM_PINS + 1) / 2;

  logic [NUM_PINS-1:0][SEL_W-1:0] sel_q;
  logic [NUM_PINS-1:0]            dir_q;
  logic                           unused_wbits;

  assign unused_wbits = ^{wdata_i[3], wdata_i[7]};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(i / 2);
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(SEL_BYTES + i / 8);
    localparam int                LSB      = (i % 2) * 4;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
        dir_q[i] <= 1'b0;
      end else if (wr_i) begin
        if (addr_i == SEL_ADDR) sel_q[i] <= wdata_i[LSB +: SEL_W];
        if (addr_i == DIR_ADDR) dir_q[i] <= wdata_i[i % 8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == ADDR_W'(i / 2))
        rdata_o[(i % 2) * 4 +: SEL_W] = sel_q[i];
      if (addr_i == ADDR_W'(SEL_BYTES + i / 8))
        rdata_o[i % 8] = dir_q[i];
    end
  end

  assign sel_o = sel_q;
  assign dir_o = dir_q;

  // R2
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i < ADDR_W'(SEL_BYTES)) |-> (rdata_o[3] == 1'b0 && rdata_o[7] == 1'b0));

  // R10
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(sel_q) && $stable(dir_q)));
endmodule

// File: rtl/prm_sync.sv
module prm_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_chk
    // R3
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_q[k] == $past(stg_q[k-1]));
  end
endmodule

// File: rtl/prm_route.sv
module prm_route
  import prm_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  logic [NUM_PINS-1:0][SEL_W-1:0] sel_i,
  input  logic [NUM_PINS-1:0]            dir_i,
  input  logic [NUM_PINS-1:0]            pin_s_i,
  output logic                           cnt0_o,
  output logic                           cnt1_o,
  output logic                           lvl_hi_o,
  output logic                           lvl_lo_o,
  output logic [NUM_PINS-1:0]            oe_o
);
  always_comb begin
    cnt0_o   = 1'b0;
    cnt1_o   = 1'b0;
    lvl_hi_o = 1'b0;
    lvl_lo_o = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      case (route_sel_e'(sel_i[i]))
        RS_CNT0:    cnt0_o   = cnt0_o   |  pin_s_i[i];
        RS_CNT1:    cnt1_o   = cnt1_o   |  pin_s_i[i];
        RS_HI_RISE: lvl_hi_o = lvl_hi_o |  pin_s_i[i];
        RS_LO_RISE: lvl_lo_o = lvl_lo_o |  pin_s_i[i];
        RS_HI_FALL: lvl_hi_o = lvl_hi_o | ~pin_s_i[i];
        RS_LO_FALL: lvl_lo_o = lvl_lo_o | ~pin_s_i[i];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
    assign oe_o[i] = dir_i[i] & (sel_i[i] == RS_NONE);
  end
endmodule

// File: rtl/prm_edge.sv
module prm_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;

  for (genvar j = 0; j < W; j++) begin : g_chk
    // R5
    single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o[j] |=> !pulse_o[j]);
  end
endmodule

// File: rtl/pin_route_matrix.sv
module pin_route_matrix
  import prm_pkg::*;
#(
  parameter int NUM_PINS    = 12,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_wr_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  output logic                cnt0_clk_o,
  output logic                cnt1_clk_o,
  output logic                irq_hi_o,
  output logic                irq_lo_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic [NUM_PINS-1:0][SEL_W-1:0] sel;
  logic [NUM_PINS-1:0]            dir;
  logic [NUM_PINS-1:0]            pin_s;
  logic                           lvl_hi, lvl_lo;
  logic [1:0]                     pulses;

  prm_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .sel_o(sel), .dir_o(dir)
  );

  prm_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  prm_route #(.NUM_PINS(NUM_PINS)) u_route (
    .sel_i(sel), .dir_i(dir), .pin_s_i(pin_s),
    .cnt0_o(cnt0_clk_o), .cnt1_o(cnt1_clk_o),
    .lvl_hi_o(lvl_hi), .lvl_lo_o(lvl_lo), .oe_o(pin_oe_o)
  );

  prm_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i({lvl_lo, lvl_hi}), .pulse_o(pulses)
  );

  assign irq_hi_o = pulses[0];
  assign irq_lo_o = pulses[1];
endmodule

// File: tb/tb_pin_route_matrix.sv
`timescale 1ns/1ps
module tb_pin_route_matrix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pin_i = '0;
  logic        cfg_wr_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        cnt0_clk_o, cnt1_clk_o, irq_hi_o, irq_lo_o;
  logic [11:0] pin_oe_o;

  int n_chk = 0;
  int n_err = 0;

  logic [2:0]  m_sel [12];
  logic [11:0] m_dir = '0;
  logic [11:0] m_pin = '0;

  always #2.5 clk = ~clk;

  pin_route_matrix dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_wr_i(cfg_wr_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .cnt0_clk_o(cnt0_clk_o), .cnt1_clk_o(cnt1_clk_o),
    .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o), .pin_oe_o(pin_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic m_or(input logic [11:0] p, input logic [2:0] code, input logic inv);
    logic r = 1'b0;
    for (int i = 0; i < 12; i++)
      if (m_sel[i] == code) r = r | (inv ? ~p[i] : p[i]);
    return r;
  endfunction

  function automatic logic m_lvl(input logic [11:0] p, input bit lo);
    return lo ? (m_or(p, 3'd5, 1'b0) | m_or(p, 3'd7, 1'b1))
              : (m_or(p, 3'd4, 1'b0) | m_or(p, 3'd6, 1'b1));
  endfunction

  function automatic logic [11:0] m_oe();
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = m_dir[i] & (m_sel[i] == 3'd0);
    return r;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    if (a < 3'd6) begin
      m_sel[2*a]   = d[2:0];
      m_sel[2*a+1] = d[6:4];
    end else if (a == 3'd6) m_dir[7:0] = d;
    else m_dir[11:8] = d[3:0];
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    cfg_addr_i = a;
    #0.5;
    chk(req, cfg_rdata_o, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_cfg();
    for (int a = 0; a < 8; a++) wr(3'(a), 8'h00);
    settle();
  endtask

  task automatic step(input logic [11:0] nv, input string req);
    logic oh, ol;
    oh = m_lvl(m_pin, 1'b0);
    ol = m_lvl(m_pin, 1'b1);
    @(negedge clk);
    pin_i = nv; m_pin = nv;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({req, " cnt0"}, cnt0_clk_o, m_or(nv, 3'd2, 1'b0));
    chk({req, " cnt1"}, cnt1_clk_o, m_or(nv, 3'd3, 1'b0));
    chk({req, " irq_hi"}, irq_hi_o, m_lvl(nv, 1'b0) & ~oh);
    chk({req, " irq_lo"}, irq_lo_o, m_lvl(nv, 1'b1) & ~ol);
    @(negedge clk);
    chk({req, " irq_hi end"}, irq_hi_o, 1'b0);
    chk({req, " irq_lo end"}, irq_lo_o, 1'b0);
  endtask

  function automatic string req_of(input int c);
    if (c < 2) return "R8";
    if (c < 4) return "R3";
    if (c < 6) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) m_sel[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 readback", 3'(a), 8'h00);
    chk("R1 outputs", {cnt0_clk_o, cnt1_clk_o, irq_hi_o, irq_lo_o}, 4'h0);
    chk("R1 oe", pin_oe_o, 12'h000);

    // R2: readback of both halves, gap bits dropped
    wr(3'd2, 8'hFF);
    rd_chk("R2 gap bits", 3'd2, 8'h77);
    wr(3'd4, 8'h51);
    rd_chk("R2 reserved code", 3'd4, 8'h51);
    clear_cfg();

    // Sweep every pin through every code
    for (int p = 0; p < 12; p++) begin
      for (int c = 0; c < 8; c++) begin
        clear_cfg();
        step(12'h000, req_of(c));
        wr(3'(p / 2), (p % 2) ? 8'(c << 4) : 8'(c));
        rd_chk("R2 sweep readback", 3'(p / 2), (p % 2) ? 8'(c << 4) : 8'(c));
        settle();
        step(12'(1) << p, req_of(c));
        step(12'h000, req_of(c));
        step(12'(1) << p, req_of(c));
      end
    end

    // R4: OR merge on counter clocks
    clear_cfg();
    step(12'h000, "R4");
    wr(3'd0, 8'h32);   // pin0 cnt0, pin1 cnt1
    wr(3'd2, 8'h20);   // pin5 cnt0
    wr(3'd5, 8'h23);   // pin10 cnt1, pin11 cnt0
    settle();
    step(12'h001, "R4");
    step(12'h021, "R4");
    step(12'h800, "R4");
    step(12'h402, "R4");
    step(12'h000, "R4");
    step(12'hC23, "R4");

    // R7: mixed polarity on one line
    clear_cfg();
    wr(3'd1, 8'h60);   // pin3 hi falling
    wr(3'd2, 8'h04);   // pin4 hi rising
    wr(3'd3, 8'h57);   // pin6 lo falling, pin7 lo rising
    settle();
    step(12'h0C8, "R7");
    step(12'h0D8, "R7");
    step(12'h0D0, "R7");
    step(12'h0C0, "R7");
    step(12'h0C8, "R7");
    step(12'h048, "R7");
    step(12'h008, "R7");
    step(12'h088, "R7");

    // R9: direction gating by selector
    clear_cfg();
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    @(negedge clk);
    chk("R9 all gpio", pin_oe_o, 12'hFFF);
    wr(3'd0, 8'h10);   // pin1 reserved code
    wr(3'd4, 8'h02);   // pin8 cnt0
    wr(3'd5, 8'h60);   // pin11 hi falling
    @(negedge clk);
    chk("R9 assigned pins", pin_oe_o, m_oe());
    wr(3'd6, 8'hA5);
    @(negedge clk);
    chk("R9 pattern", pin_oe_o, m_oe());
    rd_chk("R9 dir readback", 3'd6, 8'hA5);

    // R10: upper bits of the second direction byte
    rd_chk("R10 upper nibble", 3'd7, 8'h0F);
    wr(3'd7, 8'hF3);
    rd_chk("R10 upper ignored", 3'd7, 8'h03);
    @(negedge clk);
    chk("R10 oe after write", pin_oe_o, m_oe());
    repeat (4) @(negedge clk);
    rd_chk("R10 hold", 3'd6, 8'hA5);
    rd_chk("R10 hold sel", 3'd5, 8'h60);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule